// File: doc/BRIEF.md
# Triggered Pattern Period Sequencer

This block gates a waveform output over time. A run control arms it. A falling edge on the trigger input starts a programmable start delay, but only if run is high when the edge is sampled. After the delay the sequencer enters its pattern-on state. That state is divided into pattern periods of programmable length. In each period the output enable is high for a programmable on-window at the start of the period. A one-cycle period-start pulse marks the first cycle of every period, so address counters downstream can rewind.

Repetition has two modes. In endless mode the periods repeat until a stop request arrives. In counted mode the sequencer runs a programmed number of periods and then returns to idle. A continuous mode holds the output enable high for the whole pattern-on state and ignores the on-window. Two conditions stop a pattern: the trigger going high, or run going low. A stop request made in the pattern-on state waits for the end of the current period. A stop request made during the start delay aborts at once.

The configuration is captured at the start edge: period, on-window, repeat mode, repeat count and continuous flag. Changes to these inputs while the block is busy have no effect until the next start. All control and status pins are plain levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pps_seq`

## Requirements
- R1: After reset, `out_en_o`, `period_start_o` and `busy_o` are all 0.
- R2: A start happens only when the clock edge samples `trig_i` low, the previous cycle sampled it high, and `run_i` is high. An edge seen while `run_i` is low does not start the block. A trigger held low does not start it either.
- R3: Call the first cycle after the start edge cycle 0. The pattern-on state begins at cycle D+1, where D is `delay_i`. `busy_o` is high from cycle 0 onward.
- R4: `period_start_o` is high for exactly the first cycle of each pattern period. The period length is P = `period_i` cycles, and a value of 0 counts as 1.
- R5: When not in continuous mode, `out_en_o` is high during the first min(`win_i`, P) cycles of each period and low for the rest of the period.
- R6: When `cont_mode_i` is 1 at start, `out_en_o` is high in every cycle of the pattern-on state.
- R7: When `rep_forever_i` is 0, the block runs N = `rep_count_i` periods (0 counts as 1) and then returns to idle. `busy_o` goes low in the cycle after the last period.
- R8: When `rep_forever_i` is 1, periods repeat without limit until a stop request arrives.
- R9: If `trig_i` is high in any cycle of the pattern-on state, the block finishes the current period and then goes idle.
- R10: If `run_i` is low in any cycle of the pattern-on state, the block finishes the current period and then goes idle.
- R11: If `trig_i` is high or `run_i` is low during the start delay, `busy_o` is 0 in the next cycle and no period is output.
- R12: After a counted run ends, the block stays idle until a new qualifying falling edge arrives. Toggling `run_i` while the trigger is held low does not restart it.
- R13: Changes to the configuration inputs after the start edge do not alter the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Arm level; low requests a stop |
| trig_i | input | 1 | Trigger; falling edge starts, high requests a stop |
| cont_mode_i | input | 1 | Continuous output for the whole pattern-on state |
| rep_forever_i | input | 1 | 1 = endless repetition, 0 = counted |
| rep_count_i | input | RPT_W | Number of periods in counted mode |
| delay_i | input | CNT_W | Start delay in cycles |
| period_i | input | CNT_W | Pattern period length in cycles |
| win_i | input | CNT_W | On-window length in cycles |
| out_en_o | output | 1 | Waveform output enable |
| period_start_o | output | 1 | One-cycle pulse at each period start |
| busy_o | output | 1 | High from the start edge until idle |

## Verification
The bench sweeps every combination of a small grid: delay, period (including 0), on-window (including values wider than the period), repeat count (including 0), and continuous mode. Cycle by cycle it compares the three outputs with positions it computes arithmetically. This grid separates an off-by-one in the delay from one in the period wrap, and it exposes a missing clamp on the window or the count. Endless runs are stopped by trigger-high and by run-low, each issued at every offset within a period, to show that the stop always lands on the period boundary. Separate sequences try three cases: an edge with run low, a trigger held low, and aborts during the delay. In one run the inputs are changed after start, to show that the configuration was captured.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_ON    = 2'd2
  } seq_st_e;
endpackage

// File: rtl/pps_edge_det.sv
module pps_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic fall_o
);
  logic prev_q;

  // Reset to low so a level that is already low at reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/pps_delay_ctr.sv
module pps_delay_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pps_period_ctr.sv
module pps_period_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] len_i,
  input  logic [W-1:0] win_i,
  output logic         first_o,
  output logic         last_o,
  output logic         in_win_o
);
  logic [W-1:0] pos_q;
  logic [W-1:0] len_eff;
  logic [W-1:0] win_eff;

  always_comb begin
    len_eff = (len_i == '0) ? {{(W-1){1'b0}}, 1'b1} : len_i;
    win_eff = (win_i > len_eff) ? len_eff : win_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (clr_i)  pos_q <= '0;
    else if (adv_i)  pos_q <= last_o ? '0 : pos_q + 1'b1;
  end

  assign first_o  = (pos_q == '0);
  assign last_o   = (pos_q == len_eff - 1'b1);
  assign in_win_o = (pos_q < win_eff);
endmodule

// File: rtl/pps_repeat_ctr.sv
module pps_repeat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] target_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] tgt_eff;

  assign tgt_eff = (target_i == '0) ? {{(W-1){1'b0}}, 1'b1} : target_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == tgt_eff - 1'b1);
endmodule

// File: rtl/pps_seq.sv
module pps_seq #(
  parameter int CNT_W = 16,
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             trig_i,
  input  logic             cont_mode_i,
  input  logic             rep_forever_i,
  input  logic [RPT_W-1:0] rep_count_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] win_i,
  output logic             out_en_o,
  output logic             period_start_o,
  output logic             busy_o
);
  import pps_pkg::*;

  typedef struct packed {
    logic             cont;
    logic             endless;
    logic [RPT_W-1:0] reps;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] win;
  } cfg_t;

  seq_st_e st_q, st_d;
  cfg_t    cfg_q;
  logic    trig_fall, start, dly_zero, abort_dly, enter_on;
  logic    st_on, pos_first, pos_last, in_win, rep_last;
  logic    stop_req, stop_pend_q, stop_now, period_done, finish;
  logic    cfg_cont;

  pps_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(trig_i), .fall_o(trig_fall)
  );

  assign st_on     = (st_q == ST_ON);
  assign start     = (st_q == ST_IDLE) && trig_fall && run_i;
  assign stop_req  = trig_i || !run_i;
  assign abort_dly = (st_q == ST_DELAY) && stop_req;
  assign enter_on  = (st_q == ST_DELAY) && !stop_req && dly_zero;

  pps_delay_ctr #(.W(CNT_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load_i(start),
    .dec_i(st_q == ST_DELAY), .val_i(delay_i), .zero_o(dly_zero)
  );

  pps_period_ctr #(.W(CNT_W)) u_per (
    .clk(clk), .rst_n(rst_n), .clr_i(!st_on), .adv_i(st_on),
    .len_i(cfg_q.period), .win_i(cfg_q.win),
    .first_o(pos_first), .last_o(pos_last), .in_win_o(in_win)
  );

  assign stop_now    = stop_pend_q || stop_req;
  assign period_done = st_on && pos_last;
  assign finish      = period_done && (stop_now || (!cfg_q.endless && rep_last));

  pps_repeat_ctr #(.W(RPT_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .clr_i(!st_on),
    .inc_i(period_done && !finish), .target_i(cfg_q.reps), .last_o(rep_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_DELAY;
      ST_DELAY: begin
        if (abort_dly)     st_d = ST_IDLE;
        else if (enter_on) st_d = ST_ON;
      end
      ST_ON:    if (finish) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cfg_q       <= '0;
      stop_pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start) begin
        cfg_q.cont    <= cont_mode_i;
        cfg_q.endless <= rep_forever_i;
        cfg_q.reps    <= rep_count_i;
        cfg_q.period  <= period_i;
        cfg_q.win     <= win_i;
      end
      if (!st_on)        stop_pend_q <= 1'b0;
      else if (stop_req) stop_pend_q <= 1'b1;
    end
  end

  assign cfg_cont       = cfg_q.cont;
  assign out_en_o       = st_on && (cfg_q.cont || in_win);
  assign period_start_o = st_on && pos_first;
  assign busy_o         = (st_q != ST_IDLE);
endmodule

// File: rtl/pps_seq_chk.sv
module pps_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic trig_i,
  input logic out_en_o,
  input logic period_start_o,
  input logic busy_o,
  input logic st_on,
  input logic pos_last,
  input logic cfg_cont
);
  assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(run_i) && !$past(trig_i)));

  assert_pulse_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |-> busy_o);

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start_o && !pos_last) |=> !period_start_o);

  assert_enable_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> busy_o);

  assert_cont_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_on && cfg_cont) |-> out_en_o);

  // R9 and R10: the pattern-on state is left only at a period boundary
  assert_stop_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_on && !pos_last) |=> st_on);
endmodule

bind pps_seq pps_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .trig_i(trig_i),
  .out_en_o(out_en_o), .period_start_o(period_start_o), .busy_o(busy_o),
  .st_on(st_on), .pos_last(pos_last), .cfg_cont(cfg_cont)
);

// File: tb/pps_seq_tb.sv
module pps_seq_tb;
  localparam int CNT_W = 16;
  localparam int RPT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0, trig_i = 1'b1, cont_mode_i = 1'b0, rep_forever_i = 1'b0;
  logic [RPT_W-1:0] rep_count_i = '0;
  logic [CNT_W-1:0] delay_i = '0, period_i = '0, win_i = '0;
  logic out_en_o, period_start_o, busy_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  pps_seq #(.CNT_W(CNT_W), .RPT_W(RPT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .trig_i(trig_i),
    .cont_mode_i(cont_mode_i), .rep_forever_i(rep_forever_i),
    .rep_count_i(rep_count_i), .delay_i(delay_i), .period_i(period_i),
    .win_i(win_i), .out_en_o(out_en_o), .period_start_o(period_start_o),
    .busy_o(busy_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // stop_kind: 0 none, 1 trigger high, 2 run low; applied during cycle c_r
  task automatic run_case(input int d, input int p, input int w, input int n,
                          input bit cont, input bit endless, input int stop_kind,
                          input int c_r, input bit scramble);
    int pe, ne, we, last_busy, rel_r, stop_end;
    @(negedge clk);
    trig_i = 1'b1; run_i = 1'b1;
    delay_i = CNT_W'(d); period_i = CNT_W'(p); win_i = CNT_W'(w);
    rep_count_i = RPT_W'(n); cont_mode_i = cont; rep_forever_i = endless;
    @(negedge clk);
    @(negedge clk);
    trig_i = 1'b0;
    pe = (p == 0) ? 1 : p;
    ne = (n == 0) ? 1 : n;
    we = (w > pe) ? pe : w;
    last_busy = endless ? 1000000 : d + ne * pe;
    if (stop_kind != 0) begin
      rel_r = c_r - d - 1;
      stop_end = d + 1 + (rel_r / pe + 1) * pe - 1;
      if (stop_end < last_busy) last_busy = stop_end;
    end
    for (int c = 0; c <= last_busy + 2; c++) begin
      int rel, pos;
      bit on;
      string breq;
      @(negedge clk);
      rel = c - d - 1;
      on  = (c >= d + 1) && (c <= last_busy);
      pos = (rel >= 0) ? rel % pe : 0;
      if (scramble)            breq = "R13";
      else if (c <= d)         breq = "R3";
      else if (stop_kind == 1) breq = "R9";
      else if (stop_kind == 2) breq = "R10";
      else if (endless)        breq = "R8";
      else                     breq = "R7";
      chk(breq, "busy", busy_o, c <= last_busy);
      chk(cont ? "R6" : "R5", "out_en", out_en_o, on && (cont || pos < we));
      chk((c == d + 1) ? "R3" : "R4", "period_start", period_start_o, on && pos == 0);
      if (scramble && c == 0) begin
        period_i = CNT_W'(p + 3); win_i = CNT_W'(0); cont_mode_i = ~cont;
        rep_count_i = RPT_W'(n + 2); delay_i = CNT_W'(9);
      end
      if (stop_kind == 1 && c == c_r) trig_i = 1'b1;
      if (stop_kind == 2 && c == c_r) run_i  = 1'b0;
    end
    trig_i = 1'b1; run_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", busy_o, 1'b0);
    chk("R1", "out_en", out_en_o, 1'b0);
    chk("R1", "period_start", period_start_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: falling edge with run low does not start
    run_i = 1'b0; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk("R2", "busy run low", busy_o, 1'b0);
    end
    // R2: trigger held low, run raised: no edge, no start
    run_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk("R2", "busy held low", busy_o, 1'b0);
    end
    trig_i = 1'b1;

    // Main sweep: delay, period, window, count, continuous
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 5; p++)
        for (int w = 0; w < 6; w++)
          for (int n = 0; n < 4; n++)
            for (int c = 0; c < 2; c++)
              run_case(d, p, w, n, c[0], 1'b0, 0, 0, 1'b0);

    // Endless runs stopped by trigger (R9) and run (R10) at every offset
    for (int p = 1; p < 5; p++)
      for (int k = 1; k < 3; k++)
        for (int off = 0; off < 2 * p; off++)
          run_case(1, p, 1, 0, 1'b0, 1'b1, k, 2 + off + p, 1'b0);

    // R13: configuration changes after start are ignored
    run_case(0, 3, 1, 3, 1'b0, 1'b0, 0, 0, 1'b1);
    run_case(2, 4, 2, 2, 1'b1, 1'b0, 0, 0, 1'b1);

    // R11: abort during delay by trigger high, then by run low
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); delay_i = 16'd5; period_i = 16'd2; win_i = 16'd1;
      rep_forever_i = 1'b1; trig_i = 1'b1; run_i = 1'b1;
      @(negedge clk); trig_i = 1'b0;
      @(negedge clk); chk("R11", "busy in delay", busy_o, 1'b1);
      if (k == 0) trig_i = 1'b1; else run_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk("R11", "busy after abort", busy_o, 1'b0);
        chk("R11", "out_en after abort", out_en_o, 1'b0);
      end
      trig_i = 1'b1; run_i = 1'b1;
    end

    // R12: after a counted run, only a new falling edge restarts
    @(negedge clk); delay_i = 16'd1; period_i = 16'd2; win_i = 16'd1;
    rep_forever_i = 1'b0; rep_count_i = 8'd2; cont_mode_i = 1'b0;
    trig_i = 1'b1; run_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R12", "busy after finish", busy_o, 1'b0);
    run_i = 1'b0;
    @(negedge clk); run_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R12", "busy run toggled", busy_o, 1'b0);
    end
    trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    @(negedge clk); chk("R12", "busy new edge", busy_o, 1'b1);
    repeat (8) @(negedge clk);
    chk("R12", "busy second finish", busy_o, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule